// File: doc/BRIEF.md
# PLL Bring-up Sequencer

This block takes two PLLs in a clock-manager register block from an unknown state to running, with no processor involved. It has a single 32-bit register master port. A start pulse runs a fixed program of register accesses over that port. The program takes its values from configuration input ports:

1. Put both PLLs into bypass.
2. Program every divider while each PLL is held in reset and power-down.
3. Release both PLLs and wait for lock.
4. Load the post-lock output counters, first with a safe value and then with their final values.
5. Leave bypass and safe mode, ungate the clocks and clear stale loss-of-lock flags.

The register block reports a busy flag that must read clear after any write that changes bypass or global control. The sequencer polls for this flag, and it polls the lock flags, under a programmable cycle timeout. If a timeout expires, the sequencer raises an error and stops. A normal run ends with `done` held high until the next start.

Top module: `pll_bringup_seq`

## Requirements
- R1: The first two writes after a valid start are 0x7 to the main bypass register (0x24) and 0x7F to the peripheral bypass register (0x84).
- R2: After every write to a bypass register or to the control register (0x00), the status register (0x04) is read repeatedly, with no other access between, until its bit 0 (busy) reads 0.
- R3: Main dividers are written at 0x28..0x3C in the order global, feedback, calibration, C0, C1, NoC divider. The peripheral dividers follow at 0x88..0xA0 in the order global, feedback, calibration, C0, C1, EMAC control, GPIO divider. Each global word is written with bits 1:0 forced to 0.
- R4: Only after all dividers are written does each global register get a read-modify-write that sets bits 1:0, main first, keeping the other bits that were read.
- R5: No output counter is written before a status read has shown bits 8 and 9 both set.
- R6: Every output counter is first written with 0xFF: main at 0x40 + 4·i for i = 0..9, then peripheral at 0xC0 + 4·i for i = 0..7. Then all get their configured final values in the same order.
- R7: Next come 0 to the main bypass, 0 to the peripheral bypass, and then a read-modify-write of the control register that clears bit 0 and keeps the other bits.
- R8: The run ends with all ones to the enable registers 0x20 and 0x80, then 0xC to the interrupt-clear register 0x08. After that `done` goes high with no further access; 59 writes are made in total.
- R9: A start while `cfgValid` is low raises `done` with no bus access at all.
- R10: The timeout is counted in cycles from the first read of a poll. If a poll response fails its condition once `tmoLimit` cycles have passed, `error` rises and stays high, `done` stays low, and no further access is made. A response that passes its condition always advances, even with `tmoLimit` = 0.
- R11: While `busValid` is high and `busReady` low, address, write data and direction stay unchanged.
- R12: After reset `busValid`, `done` and `error` are low.
- R13: Read data is valid in the cycle where `busValid` and `busReady` are both high on a read. Register byte addresses are control 0x00, status 0x04, interrupt clear 0x08, main enable 0x20, main bypass 0x24 and peripheral enable 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that starts a run |
| cfgValid | input | 1 | Configuration inputs are valid |
| tmoLimit | input | TMO_W | Poll timeout in cycles |
| mainGlobCfg | input | 32 | Main PLL global word |
| mainFbCfg | input | 32 | Main PLL feedback word |
| mainCalCfg | input | 32 | Main PLL calibration word |
| mainC0Cfg | input | 32 | Main PLL C0 word |
| mainC1Cfg | input | 32 | Main PLL C1 word |
| mainNocCfg | input | 32 | Main NoC divider word |
| perGlobCfg | input | 32 | Peripheral PLL global word |
| perFbCfg | input | 32 | Peripheral PLL feedback word |
| perCalCfg | input | 32 | Peripheral PLL calibration word |
| perC0Cfg | input | 32 | Peripheral PLL C0 word |
| perC1Cfg | input | 32 | Peripheral PLL C1 word |
| perEmacCfg | input | 32 | Peripheral EMAC control word |
| perGpioCfg | input | 32 | Peripheral GPIO divider word |
| mainCntCfg | input | 32·MAIN_NCNT | Main output counter final values, entry i at bits 32i+31:32i |
| perCntCfg | input | 32·PER_NCNT | Peripheral output counter final values |
| busValid | output | 1 | Access request |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | ADDR_W | Byte address |
| busWdata | output | 32 | Write data |
| busReady | input | 1 | Access accepted |
| busRdata | input | 32 | Read data |
| done | output | 1 | Run completed |
| error | output | 1 | Poll timeout, terminal |

## Verification
The timeout paths are the hardest to reach, because a working register block never leaves the sequencer stuck. The bench's register model has knobs to delay lock by a chosen number of status reads, hold lock off for good, or keep busy set for good. These knobs drive both error exits, and the bench checks that the bus goes quiet after each. The opposite corner, `tmoLimit` = 0 with conditions met on the first read, runs with busy delays off and immediate lock, so that only the priority of a passing response over an expired count lets the run finish.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    OP_WR, OP_SET, OP_CLR, OP_POLL, OP_LOCK, OP_END
  } seqOp_e;

  typedef struct packed {
    logic stepClr;
    logic stepInc;
    logic capture;
    logic tmoClr;
    logic tmoRun;
  } seqStrobe_t;

  // register byte addresses
  localparam int A_CTRL      = 'h00;
  localparam int A_STAT      = 'h04;
  localparam int A_IRQCLR    = 'h08;
  localparam int A_MAIN_EN   = 'h20;
  localparam int A_MAIN_BYP  = 'h24;
  localparam int A_MAIN_GLOB = 'h28;
  localparam int A_MAIN_CNT  = 'h40;
  localparam int A_PER_EN    = 'h80;
  localparam int A_PER_BYP   = 'h84;
  localparam int A_PER_GLOB  = 'h88;
  localparam int A_PER_CNT   = 'hC0;

  localparam int MAIN_DIV_N = 6;
  localparam int PER_DIV_N  = 7;
  localparam int DIV_N      = MAIN_DIV_N + PER_DIV_N;

  localparam logic [31:0] MAIN_BYP_ALL = 32'h7;
  localparam logic [31:0] PER_BYP_ALL  = 32'h7F;
  localparam logic [31:0] RELEASE_BITS = 32'h3;
  localparam logic [31:0] SAFE_BIT     = 32'h1;
  localparam logic [31:0] SAFE_CNT_VAL = 32'hFF;
  localparam logic [31:0] LOSS_FLAGS   = 32'hC;
  localparam logic [31:0] ALL_ON       = 32'hFFFF_FFFF;

endpackage

// File: rtl/pll_seq_dp.sv
module pll_seq_dp
  import pll_seq_pkg::*;
#(
  parameter int MAIN_NCNT = 10,
  parameter int PER_NCNT  = 8,
  parameter int TMO_W     = 16,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobe_t                 strobe,
  input  logic [DIV_N-1:0][31:0]     divCfg,
  input  logic [MAIN_NCNT*32-1:0]    mainCnt,
  input  logic [PER_NCNT*32-1:0]     perCnt,
  input  logic [TMO_W-1:0]           tmoLimit,
  input  logic [31:0]                busRdata,
  output seqOp_e                     opKind,
  output logic                       pollOk,
  output logic                       tmoExpired,
  output logic [ADDR_W-1:0]          busAddr,
  output logic [31:0]                busWdata
);
  localparam int CNT_N    = MAIN_NCNT + PER_NCNT;
  localparam int ST_DIV   = 4;
  localparam int ST_REL   = ST_DIV + DIV_N;
  localparam int ST_LOCK  = ST_REL + 2;
  localparam int ST_SAFE  = ST_LOCK + 1;
  localparam int ST_FINAL = ST_SAFE + CNT_N;
  localparam int ST_TAIL  = ST_FINAL + CNT_N;
  localparam int ST_LAST  = ST_TAIL + 9;
  localparam int STEP_W   = $clog2(ST_LAST + 1);
  localparam int CI_W     = $clog2(CNT_N);
  localparam int DI_W     = $clog2(DIV_N);

  logic [STEP_W-1:0] stepQ;
  logic [TMO_W-1:0]  tmoCnt;
  logic [31:0]       capQ;
  logic [31:0]       opData;
  logic [31:0]       cntFinal [CNT_N];
  logic [CI_W-1:0]   cIdx;
  logic [DI_W-1:0]   dIdx;

  for (genvar g = 0; g < MAIN_NCNT; g++) begin : g_mainCnt
    assign cntFinal[g] = mainCnt[g*32 +: 32];
  end
  for (genvar g = 0; g < PER_NCNT; g++) begin : g_perCnt
    assign cntFinal[MAIN_NCNT+g] = perCnt[g*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ  <= '0;
      tmoCnt <= '0;
      capQ   <= '0;
    end else begin
      if (strobe.stepClr)      stepQ <= '0;
      else if (strobe.stepInc) stepQ <= stepQ + STEP_W'(1);
      if (strobe.tmoClr)                  tmoCnt <= '0;
      else if (strobe.tmoRun && !tmoExpired) tmoCnt <= tmoCnt + TMO_W'(1);
      if (strobe.capture) capQ <= busRdata;
    end
  end

  // program decode: one access per step
  always_comb begin
    int s;
    int ci;
    s      = int'(stepQ);
    ci     = 0;
    opKind = OP_END;
    busAddr = '0;
    opData = '0;
    cIdx   = '0;
    dIdx   = '0;
    if (s < ST_DIV) begin
      if (s[0]) begin
        opKind  = OP_POLL;
        busAddr = ADDR_W'(A_STAT);
      end else begin
        opKind  = OP_WR;
        busAddr = (s == 0) ? ADDR_W'(A_MAIN_BYP) : ADDR_W'(A_PER_BYP);
        opData  = (s == 0) ? MAIN_BYP_ALL : PER_BYP_ALL;
      end
    end else if (s < ST_REL) begin
      ci      = s - ST_DIV;
      dIdx    = DI_W'(ci);
      opKind  = OP_WR;
      busAddr = (ci < MAIN_DIV_N) ? ADDR_W'(A_MAIN_GLOB + 4*ci)
                                  : ADDR_W'(A_PER_GLOB + 4*(ci - MAIN_DIV_N));
      opData  = divCfg[dIdx];
      if (ci == 0 || ci == MAIN_DIV_N) opData = opData & ~RELEASE_BITS;
    end else if (s < ST_LOCK) begin
      opKind  = OP_SET;
      busAddr = (s == ST_REL) ? ADDR_W'(A_MAIN_GLOB) : ADDR_W'(A_PER_GLOB);
      opData  = RELEASE_BITS;
    end else if (s == ST_LOCK) begin
      opKind  = OP_LOCK;
      busAddr = ADDR_W'(A_STAT);
    end else if (s < ST_TAIL) begin
      ci      = (s < ST_FINAL) ? s - ST_SAFE : s - ST_FINAL;
      cIdx    = CI_W'(ci);
      opKind  = OP_WR;
      busAddr = (ci < MAIN_NCNT) ? ADDR_W'(A_MAIN_CNT + 4*ci)
                                 : ADDR_W'(A_PER_CNT + 4*(ci - MAIN_NCNT));
      opData  = (s < ST_FINAL) ? SAFE_CNT_VAL : cntFinal[cIdx];
    end else begin
      case (s - ST_TAIL)
        0: begin opKind = OP_WR;   busAddr = ADDR_W'(A_MAIN_BYP); opData = '0;         end
        2: begin opKind = OP_WR;   busAddr = ADDR_W'(A_PER_BYP);  opData = '0;         end
        4: begin opKind = OP_CLR;  busAddr = ADDR_W'(A_CTRL);     opData = SAFE_BIT;   end
        6: begin opKind = OP_WR;   busAddr = ADDR_W'(A_MAIN_EN);  opData = ALL_ON;     end
        7: begin opKind = OP_WR;   busAddr = ADDR_W'(A_PER_EN);   opData = ALL_ON;     end
        8: begin opKind = OP_WR;   busAddr = ADDR_W'(A_IRQCLR);   opData = LOSS_FLAGS; end
        1, 3, 5: begin opKind = OP_POLL; busAddr = ADDR_W'(A_STAT); end
        default: opKind = OP_END;
      endcase
    end
  end

  always_comb begin
    case (opKind)
      OP_SET:  busWdata = capQ | opData;
      OP_CLR:  busWdata = capQ & ~opData;
      default: busWdata = opData;
    endcase
  end

  assign pollOk     = (opKind == OP_POLL) ? !busRdata[0]
                    : (opKind == OP_LOCK) ? (busRdata[8] && busRdata[9]) : 1'b0;
  assign tmoExpired = (tmoCnt >= tmoLimit);

  AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (opKind == OP_POLL && strobe.stepInc) |-> !busRdata[0]); // R2
  AST_LOCK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (opKind == OP_LOCK && strobe.stepInc) |-> (busRdata[8] && busRdata[9])); // R5

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cfgValid,
  input  logic       busReady,
  input  seqOp_e     opKind,
  input  logic       pollOk,
  input  logic       tmoExpired,
  output seqStrobe_t strobe,
  output logic       busValid,
  output logic       busWrite,
  output logic       done,
  output logic       error
);
  typedef enum logic [2:0] {
    C_IDLE, C_FETCH, C_WRITE, C_READ, C_POLL, C_DONE, C_FAULT
  } ctrlState_e;

  ctrlState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= C_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      C_IDLE, C_DONE: begin
        if (start) begin
          if (cfgValid) begin
            strobe.stepClr = 1'b1;
            stateD = C_FETCH;
          end else begin
            stateD = C_DONE;
          end
        end
      end
      C_FETCH: begin
        case (opKind)
          OP_WR:           stateD = C_WRITE;
          OP_SET, OP_CLR:  stateD = C_READ;
          OP_POLL, OP_LOCK: begin
            strobe.tmoClr = 1'b1;
            stateD = C_POLL;
          end
          default:         stateD = C_DONE;
        endcase
      end
      C_READ: begin
        if (busReady) begin
          strobe.capture = 1'b1;
          stateD = C_WRITE;
        end
      end
      C_WRITE: begin
        if (busReady) begin
          strobe.stepInc = 1'b1;
          stateD = C_FETCH;
        end
      end
      C_POLL: begin
        strobe.tmoRun = 1'b1;
        if (busReady) begin
          if (pollOk) begin
            strobe.stepInc = 1'b1;
            stateD = C_FETCH;
          end else if (tmoExpired) begin
            stateD = C_FAULT;
          end
        end
      end
      C_FAULT: stateD = C_FAULT;
      default: stateD = C_IDLE;
    endcase
  end

  assign busValid = (stateQ == C_WRITE) || (stateQ == C_READ) || (stateQ == C_POLL);
  assign busWrite = (stateQ == C_WRITE);
  assign done     = (stateQ == C_DONE);
  assign error    = (stateQ == C_FAULT);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    error |=> error); // R10
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> $past(tmoExpired)); // R10

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pll_seq_pkg::*;
#(
  parameter int MAIN_NCNT = 10,
  parameter int PER_NCNT  = 8,
  parameter int TMO_W     = 16,
  parameter int ADDR_W    = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    cfgValid,
  input  logic [TMO_W-1:0]        tmoLimit,
  input  logic [31:0]             mainGlobCfg,
  input  logic [31:0]             mainFbCfg,
  input  logic [31:0]             mainCalCfg,
  input  logic [31:0]             mainC0Cfg,
  input  logic [31:0]             mainC1Cfg,
  input  logic [31:0]             mainNocCfg,
  input  logic [31:0]             perGlobCfg,
  input  logic [31:0]             perFbCfg,
  input  logic [31:0]             perCalCfg,
  input  logic [31:0]             perC0Cfg,
  input  logic [31:0]             perC1Cfg,
  input  logic [31:0]             perEmacCfg,
  input  logic [31:0]             perGpioCfg,
  input  logic [MAIN_NCNT*32-1:0] mainCntCfg,
  input  logic [PER_NCNT*32-1:0]  perCntCfg,
  output logic                    busValid,
  output logic                    busWrite,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [31:0]             busWdata,
  input  logic                    busReady,
  input  logic [31:0]             busRdata,
  output logic                    done,
  output logic                    error
);
  seqStrobe_t             strobe;
  seqOp_e                 opKind;
  logic                   pollOk;
  logic                   tmoExpired;
  logic [DIV_N-1:0][31:0] divCfg;

  assign divCfg = {perGpioCfg, perEmacCfg, perC1Cfg, perC0Cfg, perCalCfg, perFbCfg,
                   perGlobCfg, mainNocCfg, mainC1Cfg, mainC0Cfg, mainCalCfg,
                   mainFbCfg, mainGlobCfg};

  pll_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgValid(cfgValid),
    .busReady(busReady), .opKind(opKind), .pollOk(pollOk),
    .tmoExpired(tmoExpired), .strobe(strobe), .busValid(busValid),
    .busWrite(busWrite), .done(done), .error(error)
  );

  pll_seq_dp #(
    .MAIN_NCNT(MAIN_NCNT), .PER_NCNT(PER_NCNT), .TMO_W(TMO_W), .ADDR_W(ADDR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divCfg(divCfg),
    .mainCnt(mainCntCfg), .perCnt(perCntCfg), .tmoLimit(tmoLimit),
    .busRdata(busRdata), .opKind(opKind), .pollOk(pollOk),
    .tmoExpired(tmoExpired), .busAddr(busAddr), .busWdata(busWdata)
  );

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) && $stable(busWdata)
                                 && $stable(busWrite))); // R11
  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)); // R10

endmodule

// File: tb/pll_bringup_seq_tb_top.sv
module pll_bringup_seq_tb_top;
  localparam int MAIN_NCNT = 10;
  localparam int PER_NCNT  = 8;
  localparam int TMO_W     = 16;
  localparam int ADDR_W    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic cfgValid = 1'b0;
  logic [TMO_W-1:0] tmoLimit = '0;
  logic [31:0] cfgDiv [13];
  logic [31:0] cfgCnt [18];
  logic [MAIN_NCNT*32-1:0] mainCntCfg;
  logic [PER_NCNT*32-1:0]  perCntCfg;
  logic busValid, busWrite, done, error;
  logic [ADDR_W-1:0] busAddr;
  logic [31:0] busWdata;
  logic busReady = 1'b0;
  logic [31:0] busRdata = '0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < MAIN_NCNT; i++) mainCntCfg[i*32 +: 32] = cfgCnt[i];
    for (int i = 0; i < PER_NCNT; i++)  perCntCfg[i*32 +: 32]  = cfgCnt[MAIN_NCNT+i];
  end

  pll_bringup_seq #(.MAIN_NCNT(MAIN_NCNT), .PER_NCNT(PER_NCNT), .TMO_W(TMO_W),
                    .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgValid(cfgValid), .tmoLimit(tmoLimit),
    .mainGlobCfg(cfgDiv[0]), .mainFbCfg(cfgDiv[1]), .mainCalCfg(cfgDiv[2]),
    .mainC0Cfg(cfgDiv[3]), .mainC1Cfg(cfgDiv[4]), .mainNocCfg(cfgDiv[5]),
    .perGlobCfg(cfgDiv[6]), .perFbCfg(cfgDiv[7]), .perCalCfg(cfgDiv[8]),
    .perC0Cfg(cfgDiv[9]), .perC1Cfg(cfgDiv[10]), .perEmacCfg(cfgDiv[11]),
    .perGpioCfg(cfgDiv[12]), .mainCntCfg(mainCntCfg), .perCntCfg(perCntCfg),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata), .done(done), .error(error)
  );

  // bench bookkeeping
  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  // register model state and knobs
  logic [31:0] regs [64];
  logic [31:0] ctrlInit;
  int busyLeft, busyMax, lockDelay, lockCnt;
  bit lockNever, busyStick, pendPoll, seenLock;
  int r2Viol, r5Viol, r11Viol, accN;
  logic [7:0]  logA [128];
  logic [31:0] logD [128];
  int logN;
  logic [7:0]  expA [128];
  logic [31:0] expD [128];
  int expN;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit isCounter(input logic [7:0] a);
    return (a >= 8'h40 && a <= 8'h64) || (a >= 8'hC0 && a <= 8'hDC);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 64; i++) regs[i] = '0;
    ctrlInit = $urandom() | 32'h1;
    regs[0] = ctrlInit;
    busyLeft = 0; lockCnt = 0; pendPoll = 0; seenLock = 0;
    r2Viol = 0; r5Viol = 0; r11Viol = 0; accN = 0; logN = 0;
  endtask

  // register block model acting as bus slave
  initial begin
    logic [7:0] a;
    logic [31:0] d, st;
    bit w;
    forever begin
      @(negedge clk);
      if (busValid) begin
        a = busAddr; w = busWrite; d = busWdata;
        accN++;
        if (pendPoll && !(!w && a == 8'h04)) r2Viol++;
        if (w && isCounter(a) && !seenLock) r5Viol++;
        repeat ($urandom_range(2, 0)) begin
          @(negedge clk);
          if (!busValid || busAddr != a || busWrite != w || busWdata != d) r11Viol++;
        end
        if (!w && a == 8'h04) begin
          st = '0;
          st[0] = busyStick || (busyLeft > 0);
          if (busyLeft > 0) busyLeft--;
          if (regs[10][1:0] == 2'b11 && regs[34][1:0] == 2'b11) begin
            if (!lockNever && lockCnt >= lockDelay) st[9:8] = 2'b11;
            lockCnt++;
          end
          if (!st[0]) pendPoll = 0;
          if (st[9:8] == 2'b11) seenLock = 1;
          busRdata = st;
        end else begin
          busRdata = regs[a[7:2]];
        end
        busReady = 1'b1;
        @(negedge clk);
        busReady = 1'b0;
        if (w) begin
          regs[a[7:2]] = d;
          logA[logN] = a; logD[logN] = d;
          if (logN < 127) logN++;
          if (a == 8'h24 || a == 8'h84 || a == 8'h00) begin
            pendPoll = 1;
            busyLeft = (busyMax == 0) ? 0 : int'($urandom_range(busyMax, 0));
          end
        end
      end
    end
  end

  task automatic push(input logic [7:0] a, input logic [31:0] d);
    expA[expN] = a; expD[expN] = d; expN++;
  endtask

  // expected write list from the requirements
  task automatic buildExp();
    expN = 0;
    push(8'h24, 32'h7); push(8'h84, 32'h7F);                        // R1
    for (int k = 0; k < 6; k++)                                      // R3
      push(8'h28 + 8'(4*k), (k == 0) ? (cfgDiv[0] & ~32'h3) : cfgDiv[k]);
    for (int k = 0; k < 7; k++)
      push(8'h88 + 8'(4*k), (k == 0) ? (cfgDiv[6] & ~32'h3) : cfgDiv[6+k]);
    push(8'h28, cfgDiv[0] | 32'h3); push(8'h88, cfgDiv[6] | 32'h3);  // R4
    for (int i = 0; i < 10; i++) push(8'h40 + 8'(4*i), 32'hFF);     // R6
    for (int i = 0; i < 8; i++)  push(8'hC0 + 8'(4*i), 32'hFF);
    for (int i = 0; i < 10; i++) push(8'h40 + 8'(4*i), cfgCnt[i]);
    for (int i = 0; i < 8; i++)  push(8'hC0 + 8'(4*i), cfgCnt[10+i]);
    push(8'h24, 32'h0); push(8'h84, 32'h0); push(8'h00, ctrlInit & ~32'h1); // R7
    push(8'h20, 32'hFFFF_FFFF); push(8'h80, 32'hFFFF_FFFF); push(8'h08, 32'hC); // R8
  endtask

  task automatic chkRange(input int lo, input int hi, input string tag);
    int bad;
    bad = -1;
    for (int i = lo; i <= hi; i++)
      if (bad < 0 && (i >= logN || logA[i] != expA[i] || logD[i] != expD[i])) bad = i;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else begin
      $display("  %s mismatch at write %0d addr %0h/%0h", tag, bad, logA[bad], expA[bad]);
      chk(1'b0, tag, logD[bad], expD[bad]);
    end
  endtask

  task automatic resetDut();
    rstN = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    modelReset();
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic randomCfg();
    for (int i = 0; i < 13; i++) cfgDiv[i] = $urandom();
    for (int i = 0; i < 18; i++) cfgCnt[i] = $urandom();
  endtask

  // mode 0 normal, 1 lock never comes, 2 busy never clears
  task automatic runSeq(input int mode, input int bMax, input int lDly, input int lim);
    int waitCnt, accSnap;
    randomCfg();
    resetDut();
    busyMax = bMax; lockDelay = lDly; tmoLimit = TMO_W'(lim);
    lockNever = (mode == 1); busyStick = (mode == 2);
    buildExp();
    cfgValid = 1'b1;
    pulseStart();
    waitCnt = 0;
    while (!done && !error && waitCnt < 20000) begin
      @(negedge clk); waitCnt++;
    end
    if (mode == 0) begin
      chk(done && !error, "R8 done without error", {30'd0, done, error}, 32'h2);
      chkRange(0, 1, "R1 R13 bypass entry");
      chkRange(2, 14, "R3 divider writes");
      chkRange(15, 16, "R4 release read-modify-write");
      chkRange(17, 52, "R6 safe then final counters");
      chkRange(53, 55, "R7 bypass exit and safe mode");
      chkRange(56, 58, "R8 enables and flag clear");
      chk(logN == 59, "R8 write count", logN, 59);
      chk(r2Viol == 0, "R2 busy poll ordering", r2Viol, 0);
      chk(r5Viol == 0 && seenLock, "R5 lock before counters", r5Viol, 0);
      chk(r11Viol == 0, "R11 request held", r11Viol, 0);
      accSnap = accN;
      repeat (5) @(negedge clk);
      chk(accN == accSnap && !busValid, "R8 quiet after done", accN, accSnap);
    end else begin
      chk(error && !done, "R10 timeout error", {30'd0, done, error}, 32'h1);
      chk(logN == ((mode == 1) ? 17 : 1), "R10 writes before stop", logN,
          (mode == 1) ? 17 : 1);
      accSnap = accN;
      repeat (20) @(negedge clk);
      chk(accN == accSnap && !busValid && error, "R10 bus quiet after error",
          accN, accSnap);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChk + 1, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    randomCfg();
    busyMax = 0; lockDelay = 0; lockNever = 0; busyStick = 0;
    modelReset();
    resetDut();
    chk(!busValid && !done && !error, "R12 reset state",
        {29'd0, busValid, done, error}, 0);

    // R9: start without valid configuration
    cfgValid = 1'b0;
    pulseStart();
    repeat (3) @(negedge clk);
    chk(done && !error, "R9 done without config", {30'd0, done, error}, 32'h2);
    chk(accN == 0, "R9 no bus access", accN, 0);

    for (int r = 0; r < 4; r++)
      runSeq(0, 3, int'($urandom_range(4, 0)), 1000);
    runSeq(0, 0, 0, 0);     // zero limit, conditions met on first read
    runSeq(1, 2, 0, 40);    // lock never arrives
    runSeq(2, 0, 0, 25);    // busy stuck after first bypass write

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule